// File: doc/BRIEF.md
# Serial Bit-Oriented Frame Receiver with Masked Address Filter

This block takes a recovered serial bit stream, one bit per cycle in which a bit-valid strobe is high, and turns it into octets. It finds frame boundaries by watching for the flag pattern, a 0, then six 1s, then a 0. Inside a frame it removes the zero that the transmitter inserts after every run of five 1s. It packs the remaining bits into octets, with the first bit received as bit 0, and runs a 16-bit CRC over everything between the flags.

Octets are released two octets late, so the two trailing check octets are never shown as payload. The first payload octet is marked as start of frame. When the closing flag arrives, a one-cycle end-of-frame pulse reports whether the frame is good or bad. The first octet after the opening flag is treated as a station address. It is compared with a match value, but only on the bit positions selected by a mask. A frame that fails this comparison produces no output at all.

A run of seven 1s aborts the current frame, and the receiver then waits for the next flag. Line decoding, storage of the received bytes and wider address or check fields are the job of neighbouring blocks.

Top module: `sdlc_frame_rx`

## Requirements
- R1: A frame starts after the pattern 0,1,1,1,1,1,1,0 (7Eh) and ends at the next such pattern. Bits received while no frame is open produce no output.
- R2: Inside a frame, a 0 that follows five consecutive 1s is discarded. It is placed neither in an octet nor in the CRC.
- R3: Octets are built with the first received bit in `outData[0]` and the eighth in `outData[7]`.
- R4: Each octet appears on `outData` with a one-cycle `outValid` pulse, two octets after it completes. The last two octets before the closing flag are therefore never output. `outSof` is high together with `outValid` on the first output octet of a frame, and only on that octet.
- R5: The CRC uses the polynomial x^16+x^12+x^5+1, shifted least-significant bit first, with preset FFFFh. It covers every octet between the flags, including the received check field. That field carries the ones complement of the CRC over the preceding octets, with the x^15 coefficient first (low byte first, each byte LSB first). At the closing flag, `outGood` is 1 only if the CRC register holds F0B8h.
- R6: A frame is accepted only if `((address ^ addrMatch) & addrMask) == 0` for its first octet. A rejected frame produces no `outValid` and no `outEof`.
- R7: Seven consecutive 1s inside an accepted frame that holds at least one bit end that frame with `outEof`=1 and `outGood`=0. After that, nothing is output until a new flag is seen.
- R8: A frame that holds fewer than 4 octets, or whose bit count is not a multiple of 8, ends with `outEof`=1 and `outGood`=0.
- R9: Two flags with no data bits between them produce no `outEof`.
- R10: `outValid`, `outSof`, `outEof` and `outGood` are registered pulses one cycle wide, issued on the edge that accepts the strobed bit. `outEof` and `outValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | `bitIn` carries a line bit this cycle |
| bitIn | input | 1 | Serial line bit |
| addrMatch | input | 8 | Address value to compare against |
| addrMask | input | 8 | 1 = compare this address bit |
| outValid | output | 1 | Payload octet valid pulse |
| outData | output | 8 | Payload octet |
| outSof | output | 1 | First payload octet of a frame |
| outEof | output | 1 | Frame ended pulse |
| outGood | output | 1 | With `outEof`: CRC and length correct |

## Verification
The address decision and the completion of the first octet happen on the same strobed bit. The comparison therefore has to use the octet that includes the bit arriving in that cycle, not the partly filled register. The bench provokes this with an address that differs from the match value only in its last-received bit (bit 7). With a full mask it checks that no octet and no end pulse leave the block. With that bit masked off it checks that the same frame passes complete and good. A second collision is between stuffed-zero removal and flag detection: the payload is chosen so that runs of five 1s precede flag-like patterns, and the bench judges the result on the exact bytes delivered.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int FLAG_LEN = 8;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;

  typedef struct packed {
    logic frameStart;
    logic pushBit;
    logic commitBit;
    logic octetDone;
    logic loadOut;
  } ctlStrobe_t;
endpackage

// File: rtl/frx_datapath.sv
module frx_datapath
  import frx_pkg::*;
#(
  parameter int OCTET_W = 8,
  parameter int HOLD = 2,
  parameter int LINE = FLAG_LEN - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic               bitIn,
  input  logic [OCTET_W-1:0] addrMatch,
  input  logic [OCTET_W-1:0] addrMask,
  output logic               addrHit,
  output logic               crcOk,
  output logic [OCTET_W-1:0] outData
);
  // bits wait here until seven newer ones prove they are not a flag
  logic [LINE-1:0]    lineSr;
  logic [OCTET_W-1:0] octetSr;
  logic [OCTET_W-1:0] holdQ [HOLD];
  logic [CRC_W-1:0]   crcReg;
  logic               oldBit;
  logic [OCTET_W-1:0] nextOctet;
  logic [CRC_W-1:0]   crcNext;
  logic               crcFb;

  always_comb begin
    oldBit    = lineSr[0];
    nextOctet = {oldBit, octetSr[OCTET_W-1:1]};
    crcFb     = crcReg[0] ^ oldBit;
    crcNext   = (crcReg >> 1) ^ (crcFb ? CRC_POLY_REV : '0);
    addrHit   = ((nextOctet ^ addrMatch) & addrMask) == '0;
    crcOk     = crcReg == CRC_RESIDUE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSr  <= '0;
      octetSr <= '0;
      crcReg  <= CRC_PRESET;
      outData <= '0;
      for (int i = 0; i < HOLD; i++) holdQ[i] <= '0;
    end else begin
      if (strb.frameStart) crcReg <= CRC_PRESET;
      if (strb.pushBit) lineSr <= {bitIn, lineSr[LINE-1:1]};
      if (strb.commitBit) begin
        octetSr <= nextOctet;
        crcReg  <= crcNext;
      end
      if (strb.octetDone) begin
        holdQ[0] <= nextOctet;
        for (int i = 1; i < HOLD; i++) holdQ[i] <= holdQ[i-1];
      end
      if (strb.loadOut) outData <= holdQ[HOLD-1];
    end
  end

  AST_LOAD_ON_OCTET: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |-> strb.octetDone); // R4
  AST_COMMIT_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitBit |-> strb.pushBit); // R1
endmodule

// File: rtl/frx_control.sv
module frx_control
  import frx_pkg::*;
#(
  parameter int OCTET_W = 8,
  parameter int HOLD = 2,
  parameter int MIN_OCTETS = 4,
  parameter int LINE = FLAG_LEN - 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       addrHit,
  input  logic       crcOk,
  output ctlStrobe_t strb,
  output logic       outValid,
  output logic       outSof,
  output logic       outEof,
  output logic       outGood
);
  localparam int FLAG_RUN  = LINE - 1;
  localparam int STUFF_RUN = FLAG_RUN - 1;
  localparam int ONES_W    = $clog2(LINE + 1);
  localparam int PEND_W    = $clog2(LINE + 1);
  localparam int BIT_W     = $clog2(OCTET_W);
  localparam int OCT_SAT   = (MIN_OCTETS > HOLD) ? MIN_OCTETS : HOLD + 1;
  localparam int OCT_W     = $clog2(OCT_SAT + 1);
  localparam logic [ONES_W-1:0] ONES_SAT_V  = ONES_W'(LINE);
  localparam logic [ONES_W-1:0] FLAG_RUN_V  = ONES_W'(FLAG_RUN);
  localparam logic [ONES_W-1:0] STUFF_RUN_V = ONES_W'(STUFF_RUN);
  localparam logic [PEND_W-1:0] LINE_V      = PEND_W'(LINE);
  localparam logic [BIT_W-1:0]  LAST_BIT_V  = BIT_W'(OCTET_W - 1);
  localparam logic [OCT_W-1:0]  OCT_SAT_V   = OCT_W'(OCT_SAT);
  localparam logic [OCT_W-1:0]  HOLD_V      = OCT_W'(HOLD);
  localparam logic [OCT_W-1:0]  MIN_OCT_V   = OCT_W'(MIN_OCTETS);

  typedef enum logic {ST_HUNT, ST_FRAME} rxState_t;

  rxState_t          state;
  logic [ONES_W-1:0] onesCnt;
  logic [PEND_W-1:0] pendCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [OCT_W-1:0]  octCnt;
  logic              dropFrame;

  logic isFlag, isAbort, isStuff, inFrame, nonEmpty, closeNow, goodNow;

  always_comb begin
    inFrame  = state == ST_FRAME;
    isFlag   = bitValid && !bitIn && onesCnt == FLAG_RUN_V;
    isAbort  = bitValid && bitIn && onesCnt == FLAG_RUN_V;
    isStuff  = bitValid && !bitIn && onesCnt == STUFF_RUN_V;
    nonEmpty = octCnt != '0 || bitCnt != '0;
    closeNow = (isFlag || isAbort) && inFrame && !dropFrame && nonEmpty;
    goodNow  = isFlag && bitCnt == '0 && octCnt >= MIN_OCT_V && crcOk;

    strb            = '0;
    strb.frameStart = isFlag;
    strb.pushBit    = bitValid && inFrame && !isFlag && !isAbort && !isStuff;
    strb.commitBit  = strb.pushBit && pendCnt == LINE_V;
    strb.octetDone  = strb.commitBit && bitCnt == LAST_BIT_V;
    strb.loadOut    = strb.octetDone && octCnt >= HOLD_V && !dropFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      onesCnt   <= '0;
      pendCnt   <= '0;
      bitCnt    <= '0;
      octCnt    <= '0;
      dropFrame <= 1'b0;
      outValid  <= 1'b0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outGood   <= 1'b0;
    end else begin
      outValid <= strb.loadOut;
      outSof   <= strb.loadOut && octCnt == HOLD_V;
      outEof   <= closeNow;
      outGood  <= closeNow && goodNow;

      if (bitValid) begin
        if (!bitIn) onesCnt <= '0;
        else if (onesCnt != ONES_SAT_V) onesCnt <= onesCnt + 1'b1;
      end

      if (isFlag) begin
        state     <= ST_FRAME;
        pendCnt   <= '0;
        bitCnt    <= '0;
        octCnt    <= '0;
        dropFrame <= 1'b0;
      end else if (isAbort) begin
        state <= ST_HUNT;
      end else if (strb.pushBit) begin
        if (pendCnt != LINE_V) pendCnt <= pendCnt + 1'b1;
        if (strb.commitBit) begin
          bitCnt <= (bitCnt == LAST_BIT_V) ? '0 : bitCnt + 1'b1;
        end
        if (strb.octetDone) begin
          if (octCnt != OCT_SAT_V) octCnt <= octCnt + 1'b1;
          if (octCnt == '0 && !addrHit) dropFrame <= 1'b1;
        end
      end
    end
  end

  AST_SOF_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid); // R4
  AST_GOOD_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> outEof); // R5
  AST_EOF_APART: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> !outValid); // R10
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R10
  AST_NO_OUT_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushBit |-> inFrame); // R1
endmodule

// File: rtl/sdlc_frame_rx.sv
module sdlc_frame_rx
  import frx_pkg::*;
#(
  parameter int OCTET_W = 8,
  parameter int MIN_OCTETS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic [OCTET_W-1:0] addrMatch,
  input  logic [OCTET_W-1:0] addrMask,
  output logic               outValid,
  output logic [OCTET_W-1:0] outData,
  output logic               outSof,
  output logic               outEof,
  output logic               outGood
);
  localparam int HOLD = CRC_W / OCTET_W;
  localparam int LINE = FLAG_LEN - 1;

  ctlStrobe_t strb;
  logic       addrHit;
  logic       crcOk;

  frx_control #(
    .OCTET_W(OCTET_W), .HOLD(HOLD), .MIN_OCTETS(MIN_OCTETS), .LINE(LINE)
  ) uCtl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .addrHit(addrHit), .crcOk(crcOk), .strb(strb),
    .outValid(outValid), .outSof(outSof), .outEof(outEof), .outGood(outGood)
  );

  frx_datapath #(
    .OCTET_W(OCTET_W), .HOLD(HOLD), .LINE(LINE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn),
    .addrMatch(addrMatch), .addrMask(addrMask),
    .addrHit(addrHit), .crcOk(crcOk), .outData(outData)
  );
endmodule

// File: tb/sdlc_frame_rx_test.sv
module sdlc_frame_rx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic [7:0] addrMatch = 8'h5A;
  logic [7:0] addrMask = 8'hFF;
  logic outValid, outSof, outEof, outGood;
  logic [7:0] outData;

  sdlc_frame_rx uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .addrMatch(addrMatch), .addrMask(addrMask),
    .outValid(outValid), .outData(outData), .outSof(outSof),
    .outEof(outEof), .outGood(outGood)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int txOnes = 0;
  logic [7:0] txBuf [0:15];
  int txLen = 0;

  logic [7:0] rxByte [0:63];
  logic rxSof [0:63];
  int rxCnt = 0;
  int eofCnt = 0;
  logic lastGood = 1'b0;
  int clashCnt = 0;
  int doubleCnt = 0;
  logic prevValid = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && rxCnt < 64) begin
        rxByte[rxCnt] = outData;
        rxSof[rxCnt] = outSof;
        rxCnt++;
      end
      if (outEof) begin
        eofCnt++;
        lastGood = outGood;
      end
      if (outValid && outEof) clashCnt++;
      if (outValid && prevValid) doubleCnt++;
      prevValid = outValid;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearCapture();
    rxCnt = 0;
    eofCnt = 0;
    lastGood = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    txOnes = 0;
  endtask

  task automatic sendDataBit(input logic b);
    sendBit(b);
    if (b) begin
      txOnes++;
      if (txOnes == 5) begin
        sendBit(1'b0);
        txOnes = 0;
      end
    end else txOnes = 0;
  endtask

  task automatic sendDataByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendDataBit(v[i]);
  endtask

  function automatic logic [15:0] crcOver(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ txBuf[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  // body of txBuf, check field, optional trailing bits; no flags
  task automatic sendBody(input bit badCrc, input int extraBits);
    logic [15:0] fcs;
    fcs = ~crcOver(txLen);
    if (badCrc) fcs = fcs ^ 16'h0001;
    for (int k = 0; k < txLen; k++) sendDataByte(txBuf[k]);
    sendDataByte(fcs[7:0]);
    sendDataByte(fcs[15:8]);
    for (int i = 0; i < extraBits; i++) sendDataBit(i[0]);
  endtask

  task automatic sendFrame(input bit badCrc, input int extraBits);
    sendFlag();
    sendBody(badCrc, extraBits);
    sendFlag();
    repeat (4) @(negedge clk);
  endtask

  task automatic expectPayload(input string tag);
    check(rxCnt == txLen, {tag, " byte count"}, rxCnt, txLen);
    for (int k = 0; k < txLen && k < rxCnt; k++) begin
      check(rxByte[k] == txBuf[k], {tag, " byte"}, rxByte[k], txBuf[k]);
      check(rxSof[k] == (k == 0), {tag, " sof"}, rxSof[k], (k == 0));
    end
  endtask

  task automatic testReset();
    check(outValid == 0 && outSof == 0, "R10 reset valid/sof", {outValid, outSof}, 0);
    check(outEof == 0 && outGood == 0, "R10 reset eof/good", {outEof, outGood}, 0);
    check(outData == 8'h00, "R10 reset data", outData, 0);
  endtask

  task automatic testHuntIgnored();
    clearCapture();
    sendDataByte(8'hA5); sendDataByte(8'h3C); sendDataByte(8'h0F);
    repeat (4) @(negedge clk);
    check(rxCnt == 0 && eofCnt == 0, "R1 bits before flag ignored", rxCnt + eofCnt, 0);
  endtask

  task automatic testBasic();
    clearCapture();
    addrMatch = 8'h5A; addrMask = 8'hFF;
    txBuf[0] = 8'h5A; txBuf[1] = 8'h13; txBuf[2] = 8'h01;
    txBuf[3] = 8'h80; txBuf[4] = 8'hC4; txLen = 5;
    sendFrame(0, 0);
    expectPayload("R3 R4 basic");
    check(eofCnt == 1, "R1 basic eof count", eofCnt, 1);
    check(lastGood == 1, "R5 basic good", lastGood, 1);
  endtask

  task automatic testStuffing();
    clearCapture();
    txBuf[0] = 8'h5A; txBuf[1] = 8'hFF; txBuf[2] = 8'h7E;
    txBuf[3] = 8'h1F; txBuf[4] = 8'hF8; txBuf[5] = 8'h7E; txLen = 6;
    sendFrame(0, 0);
    expectPayload("R2 stuffed");
    check(eofCnt == 1 && lastGood == 1, "R2 stuffed frame good", {eofCnt[3:0], lastGood}, 5'h03);
  endtask

  task automatic testBadCrc();
    clearCapture();
    txBuf[0] = 8'h5A; txBuf[1] = 8'h20; txBuf[2] = 8'h99; txLen = 3;
    sendFrame(1, 0);
    check(eofCnt == 1, "R5 bad crc eof", eofCnt, 1);
    check(lastGood == 0, "R5 bad crc flagged", lastGood, 0);
  endtask

  task automatic testAddress();
    clearCapture();
    addrMatch = 8'h5A; addrMask = 8'hFF;
    txBuf[0] = 8'hDA; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txLen = 3;
    sendFrame(0, 0);
    check(rxCnt == 0, "R6 mismatch no bytes", rxCnt, 0);
    check(eofCnt == 0, "R6 mismatch no eof", eofCnt, 0);
    clearCapture();
    addrMask = 8'h7F;
    sendFrame(0, 0);
    expectPayload("R6 masked bit");
    check(eofCnt == 1 && lastGood == 1, "R6 masked accept good", {eofCnt[3:0], lastGood}, 5'h03);
    addrMask = 8'hFF;
  endtask

  task automatic testAbort();
    clearCapture();
    sendFlag();
    sendDataByte(8'h5A); sendDataByte(8'h10); sendDataByte(8'h22); sendDataByte(8'h33);
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    repeat (4) @(negedge clk);
    check(eofCnt == 1, "R7 abort eof", eofCnt, 1);
    check(lastGood == 0, "R7 abort bad", lastGood, 0);
    check(rxCnt == 1 && rxByte[0] == 8'h5A, "R7 abort bytes", rxCnt, 1);
    clearCapture();
    sendBit(1'b0);
    sendDataByte(8'h12); sendDataByte(8'h34); sendDataByte(8'h56);
    sendDataByte(8'h78); sendDataByte(8'h00);
    repeat (4) @(negedge clk);
    check(rxCnt == 0 && eofCnt == 0, "R7 ignored after abort", rxCnt + eofCnt, 0);
    txBuf[0] = 8'h5A; txBuf[1] = 8'h44; txLen = 2;
    sendFrame(0, 0);
    expectPayload("R7 recovery");
    check(lastGood == 1, "R7 recovery good", lastGood, 1);
  endtask

  task automatic testLength();
    clearCapture();
    txBuf[0] = 8'h5A; txLen = 1;
    sendFrame(0, 0);
    check(eofCnt == 1 && lastGood == 0, "R8 short frame bad", {eofCnt[3:0], lastGood}, 5'h02);
    check(rxCnt == 1, "R8 short frame byte count", rxCnt, 1);
    clearCapture();
    txBuf[0] = 8'h5A; txBuf[1] = 8'h55; txBuf[2] = 8'h66; txLen = 3;
    sendFrame(0, 3);
    check(eofCnt == 1 && lastGood == 0, "R8 odd bit count bad", {eofCnt[3:0], lastGood}, 5'h02);
  endtask

  task automatic testBackToBack();
    clearCapture();
    sendFlag(); sendFlag(); sendFlag();
    repeat (4) @(negedge clk);
    check(eofCnt == 0 && rxCnt == 0, "R9 empty flags", eofCnt + rxCnt, 0);
    txBuf[0] = 8'h5A; txBuf[1] = 8'h03; txBuf[2] = 8'hEE; txLen = 3;
    sendBody(0, 0);
    sendFlag();
    repeat (4) @(negedge clk);
    expectPayload("R9 frame after shared flags");
    check(eofCnt == 1 && lastGood == 1, "R9 frame good", {eofCnt[3:0], lastGood}, 5'h03);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testHuntIgnored();
    testBasic();
    testStuffing();
    testBadCrc();
    testAddress();
    testAbort();
    testLength();
    testBackToBack();
    check(clashCnt == 0, "R10 eof with valid", clashCnt, 0);
    check(doubleCnt == 0, "R10 valid pulse width", doubleCnt, 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end
endmodule